// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block holds a bank of software-programmable address windows and resolves CPU physical addresses against them. Each window is a range of a 36-bit physical address space. It is tagged with a 4-bit target code and an 8-bit attribute code, and those two codes name the device behind it. Software loads the windows through a simple 32-bit register write port with a combinational read port. The lookup side is purely combinational: it takes an address and returns a hit flag, the winning window number, its target and attribute codes, and the translated address.

Window sizes are whole multiples of 64 KiB. Software stores a size as the count of 64 KiB units minus one. Only the lowest windows (eight by default, out of twenty) own a remap base that relocates the hit address. The other windows pass the address through unchanged. Because of this, the register offset map is irregular. The remappable windows take 16-byte groups, a 16-byte reserved gap follows them, and the remaining windows take packed 8-byte groups.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset every register reads zero, every window is disabled and every lookup misses.
- R2: A window's control register at group offset +0 holds the enable flag in bit 0, the target code in bits 7:4, the attribute code in bits 15:8 and the window size minus one, in 64 KiB units, in bits 31:16. Bits 3:1 read back as zero.
- R3: A window's base register at group offset +4 holds physical address bits 31:16 in its bits 31:16 and physical address bits 35:32 in its bits 3:0. All other bits read back as zero.
- R4: Window w for w below 8 has its register group at byte offset w*16: control at +0, base at +4, remap-low at +8 (bits 31:16 kept) and remap-high at +12 (bits 3:0 kept). All other bits read zero.
- R5: Window w for w from 8 to 19 has its register group at byte offset 0x90 + (w-8)*8, with control at +0 and base at +4 only. Address bits 1:0 of the register port are ignored.
- R6: Offsets 0x80 to 0x8F and offsets 0xF0 and above read as zero, and writes to them change no window.
- R7: A window matches an address only when its enable flag is set and base <= address < base + size.
- R8: When more than one window matches, the lowest-numbered matching window supplies all lookup outputs.
- R9: On a hit in a window below 8, the translated address is {remap-high[3:0], remap-low[31:16], 16'h0} ORed with (address - base).
- R10: On a hit in a window numbered 8 or above, the translated address equals the lookup address.
- R11: On a miss, the hit flag is 0, and the window number, target, attribute and translated address are all zero.
- R12: Writing zero to a window's control register disables that window, and the window stops matching from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one word per cycle |
| reg_addr | input | 8 | Register byte offset for both write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| lk_addr | input | 36 | Physical address to look up |
| lk_hit | output | 1 | Some enabled window matches lk_addr |
| lk_win | output | 5 | Number of the winning window |
| lk_target | output | 4 | Target code of the winning window |
| lk_attr | output | 8 | Attribute code of the winning window |
| lk_xaddr | output | 36 | Translated address |

## Verification
The assertions check several properties on every cycle:
- a hit always comes from an enabled window that matches;
- no lower-numbered window matched when a higher one was chosen;
- a miss drives all outputs to zero;
- a non-remappable hit returns its input address;
- a remappable hit keeps the low 16 offset bits;
- writes to unmapped offsets leave all window state unchanged.

The exact field packing, the irregular offset map, the inclusive and exclusive range limits and the remap arithmetic depend on concrete values. Only the bench's programmed windows and their expected readback and lookup results can show these.

// File: rtl/awd_pkg.sv
package awd_pkg;

    localparam int PA_W = 36;

    typedef struct packed {
        logic [15:0] size_m1;
        logic [7:0]  attr;
        logic [3:0]  target;
        logic        en;
        logic [3:0]  base_hi;
        logic [15:0] base_lo;
        logic [15:0] rmp_lo;
        logic [3:0]  rmp_hi;
    } win_cfg_t;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_BASE = 2'd1,
        SEL_RLO  = 2'd2,
        SEL_RHI  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
    import awd_pkg::*;
#(
    parameter int NUM_WIN   = 20,
    parameter int NUM_REMAP = 8,
    parameter int REG_AW    = 8,
    localparam int IDX_W    = $clog2(NUM_WIN)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_we,
    input  logic [REG_AW-1:0]        reg_addr,
    input  logic [31:0]              reg_wdata,
    output logic [31:0]              reg_rdata,
    output win_cfg_t [NUM_WIN-1:0]   cfg_o
);

    localparam int RMP_SPAN = NUM_REMAP * 16;
    localparam int HI_START = RMP_SPAN + 16;

    win_cfg_t [NUM_WIN-1:0] cfg_d, cfg_q;

    logic             dec_ok;
    logic [IDX_W-1:0] dec_win;
    reg_sel_e         dec_sel;
    logic [31:0]      off32;
    logic [31:0]      rel32;
    logic [31:0]      idx32;

    // Offset decode: remappable groups, reserved gap, then packed groups
    always_comb begin
        off32   = 32'(reg_addr);
        rel32   = '0;
        idx32   = '0;
        dec_ok  = 1'b0;
        dec_win = '0;
        dec_sel = SEL_CTRL;
        if (off32 < RMP_SPAN) begin
            dec_ok  = 1'b1;
            dec_win = IDX_W'(off32 >> 4);
            dec_sel = reg_sel_e'(off32[3:2]);
        end else if (off32 >= HI_START) begin
            rel32 = off32 - HI_START;
            idx32 = NUM_REMAP + (rel32 >> 3);
            if (idx32 < NUM_WIN) begin
                dec_ok  = 1'b1;
                dec_win = IDX_W'(idx32);
                dec_sel = rel32[2] ? SEL_BASE : SEL_CTRL;
            end
        end
    end

    // Next-state computation
    always_comb begin
        cfg_d = cfg_q;
        if (reg_we && dec_ok) begin
            case (dec_sel)
                SEL_CTRL: begin
                    cfg_d[dec_win].size_m1 = reg_wdata[31:16];
                    cfg_d[dec_win].attr    = reg_wdata[15:8];
                    cfg_d[dec_win].target  = reg_wdata[7:4];
                    cfg_d[dec_win].en      = reg_wdata[0];
                end
                SEL_BASE: begin
                    cfg_d[dec_win].base_lo = reg_wdata[31:16];
                    cfg_d[dec_win].base_hi = reg_wdata[3:0];
                end
                SEL_RLO:  cfg_d[dec_win].rmp_lo = reg_wdata[31:16];
                default:  cfg_d[dec_win].rmp_hi = reg_wdata[3:0];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    // Read mux
    always_comb begin
        reg_rdata = '0;
        if (dec_ok) begin
            case (dec_sel)
                SEL_CTRL: reg_rdata = {cfg_q[dec_win].size_m1, cfg_q[dec_win].attr,
                                       cfg_q[dec_win].target, 3'b000, cfg_q[dec_win].en};
                SEL_BASE: reg_rdata = {cfg_q[dec_win].base_lo, 12'h000,
                                       cfg_q[dec_win].base_hi};
                SEL_RLO:  reg_rdata = {cfg_q[dec_win].rmp_lo, 16'h0000};
                default:  reg_rdata = {28'h0, cfg_q[dec_win].rmp_hi};
            endcase
        end
    end

    assign cfg_o = cfg_q;

    // R6: writes to unmapped offsets leave every window untouched
    p_rsvd_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !dec_ok) |=> $stable(cfg_q));

endmodule

// File: rtl/awd_win_match.sv
module awd_win_match
    import awd_pkg::*;
#(
    parameter bit REMAP_EN = 1'b1
) (
    input  win_cfg_t         cfg_i,
    input  logic [PA_W-1:0]  lk_addr,
    output logic             match_o,
    output logic [PA_W-1:0]  xaddr_o
);

    logic [PA_W-1:0] base;
    logic [16:0]     sz_units;
    logic [PA_W:0]   lim;
    logic [PA_W-1:0] offs;

    always_comb begin
        base     = {cfg_i.base_hi, cfg_i.base_lo, 16'h0000};
        sz_units = {1'b0, cfg_i.size_m1} + 17'd1;
        lim      = {1'b0, base} + {4'b0000, sz_units, 16'h0000};
        offs     = lk_addr - base;
        match_o  = cfg_i.en && (lk_addr >= base) && ({1'b0, lk_addr} < lim);
    end

    generate
        if (REMAP_EN) begin : g_remap
            assign xaddr_o = {cfg_i.rmp_hi, cfg_i.rmp_lo, 16'h0000} | offs;
        end else begin : g_pass
            assign xaddr_o = lk_addr;
        end
    endgenerate

endmodule

// File: rtl/awd_pick.sv
module awd_pick
    import awd_pkg::*;
#(
    parameter int NUM_WIN   = 20,
    parameter int NUM_REMAP = 8,
    localparam int IDX_W    = $clog2(NUM_WIN)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [PA_W-1:0]                    lk_addr,
    input  logic [NUM_WIN-1:0]                 match_vec,
    input  logic [NUM_WIN-1:0][PA_W-1:0]       xaddr_vec,
    input  win_cfg_t [NUM_WIN-1:0]             cfg_i,
    output logic                               hit_o,
    output logic [IDX_W-1:0]                   win_o,
    output logic [3:0]                         target_o,
    output logic [7:0]                         attr_o,
    output logic [PA_W-1:0]                    xaddr_o
);

    // Scan downward so the lowest matching index is written last
    always_comb begin
        hit_o    = 1'b0;
        win_o    = '0;
        target_o = '0;
        attr_o   = '0;
        xaddr_o  = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit_o    = 1'b1;
                win_o    = IDX_W'(i);
                target_o = cfg_i[i].target;
                attr_o   = cfg_i[i].attr;
                xaddr_o  = xaddr_vec[i];
            end
        end
    end

    // R7: a hit only comes from an enabled window that matched
    p_hit_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (cfg_i[win_o].en && match_vec[win_o]));

    // R8: no lower-numbered window matched
    p_lowest_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> ((match_vec & ((NUM_WIN'(1) << win_o) - NUM_WIN'(1))) == '0));

    // R11: a miss drives everything to zero
    p_miss_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (win_o == '0 && target_o == '0 && attr_o == '0 && xaddr_o == '0));

    // R10: non-remappable hits pass the address through
    p_passthru_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && 32'(win_o) >= NUM_REMAP) |-> (xaddr_o == lk_addr));

    // R9: remapped hits keep the in-window low offset bits
    p_remap_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && 32'(win_o) < NUM_REMAP) |-> (xaddr_o[15:0] == lk_addr[15:0]));

endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
    import awd_pkg::*;
#(
    parameter int NUM_WIN   = 20,
    parameter int NUM_REMAP = 8,
    parameter int REG_AW    = 8,
    localparam int IDX_W    = $clog2(NUM_WIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [PA_W-1:0]   lk_addr,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_win,
    output logic [3:0]        lk_target,
    output logic [7:0]        lk_attr,
    output logic [PA_W-1:0]   lk_xaddr
);

    win_cfg_t [NUM_WIN-1:0]         cfg;
    logic [NUM_WIN-1:0]             match_vec;
    logic [NUM_WIN-1:0][PA_W-1:0]   xaddr_vec;

    awd_regfile #(
        .NUM_WIN   (NUM_WIN),
        .NUM_REMAP (NUM_REMAP),
        .REG_AW    (REG_AW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cfg_o     (cfg)
    );

    generate
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
            awd_win_match #(
                .REMAP_EN (w < NUM_REMAP)
            ) u_match (
                .cfg_i   (cfg[w]),
                .lk_addr (lk_addr),
                .match_o (match_vec[w]),
                .xaddr_o (xaddr_vec[w])
            );
        end
    endgenerate

    awd_pick #(
        .NUM_WIN   (NUM_WIN),
        .NUM_REMAP (NUM_REMAP)
    ) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_addr   (lk_addr),
        .match_vec (match_vec),
        .xaddr_vec (xaddr_vec),
        .cfg_i     (cfg),
        .hit_o     (lk_hit),
        .win_o     (lk_win),
        .target_o  (lk_target),
        .attr_o    (lk_attr),
        .xaddr_o   (lk_xaddr)
    );

endmodule

// File: tb/addr_window_decoder_bench.sv
module addr_window_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [35:0] lk_addr;
    logic        lk_hit;
    logic [4:0]  lk_win;
    logic [3:0]  lk_target;
    logic [7:0]  lk_attr;
    logic [35:0] lk_xaddr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    addr_window_decoder u_addr_window_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .lk_addr   (lk_addr),
        .lk_hit    (lk_hit),
        .lk_win    (lk_win),
        .lk_target (lk_target),
        .lk_attr   (lk_attr),
        .lk_xaddr  (lk_xaddr)
    );

    typedef struct packed {
        logic [35:0] a;
        logic        h;
        logic [4:0]  w;
        logic [3:0]  t;
        logic [7:0]  at;
        logic [35:0] x;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [0:NV-1] = '{
        '{36'h0_1000_0000, 1'b1, 5'd0,  4'h3, 8'h1D, 36'h2_A000_0000}, // R7 base inclusive, R9
        '{36'h0_1002_3456, 1'b1, 5'd0,  4'h3, 8'h1D, 36'h2_A002_3456}, // R8 overlap, R9
        '{36'h0_100F_FFFF, 1'b1, 5'd0,  4'h3, 8'h1D, 36'h2_A00F_FFFF}, // R8 last byte of W0
        '{36'h0_1010_0000, 1'b1, 5'd9,  4'h7, 8'h0A, 36'h0_1010_0000}, // R10
        '{36'h0_10FF_FFFF, 1'b1, 5'd9,  4'h7, 8'h0A, 36'h0_10FF_FFFF}, // R10 last byte
        '{36'h0_1100_0000, 1'b0, 5'd0,  4'h0, 8'h00, 36'h0},           // R7 limit exclusive, R11
        '{36'h0_0FFF_FFFF, 1'b0, 5'd0,  4'h0, 8'h00, 36'h0},           // R7 below base, R6
        '{36'h2_3000_1234, 1'b1, 5'd2,  4'h5, 8'h22, 36'h0_0000_1234}, // R3 high base, R9
        '{36'h0_3000_1234, 1'b0, 5'd0,  4'h0, 8'h00, 36'h0},           // R3 high bits matter
        '{36'h2_3001_0000, 1'b0, 5'd0,  4'h0, 8'h00, 36'h0},           // R7 64 KiB window end
        '{36'h0_F001_FFFF, 1'b1, 5'd19, 4'h9, 8'h4C, 36'h0_F001_FFFF}, // R5 last window
        '{36'h0_F002_0000, 1'b0, 5'd0,  4'h0, 8'h00, 36'h0},           // R7
        '{36'h0_5000_0000, 1'b0, 5'd0,  4'h0, 8'h00, 36'h0}            // R7 disabled window
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        reg_addr = a;
        #1;
        check(reg_rdata == exp, req, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic look(input logic [35:0] a, input logic h, input logic [4:0] w,
                        input logic [3:0] t, input logic [7:0] at, input logic [35:0] x,
                        input string req);
        logic [53:0] act;
        logic [53:0] exp;
        lk_addr = a;
        #1;
        act = {lk_hit, lk_win, lk_target, lk_attr, lk_xaddr};
        exp = {h, w, t, at, x};
        check(act == exp, req, 64'(act), 64'(exp));
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        reg_we    = 1'b0;
        reg_addr  = '0;
        reg_wdata = '0;
        lk_addr   = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        rd_chk(8'h00, 32'h0, "R1 ctrl w0 after reset");
        look(36'h0, 1'b0, 5'd0, 4'h0, 8'h00, 36'h0, "R1 lookup misses in reset");
        rst_n = 1'b1;
        @(negedge clk);
        rd_chk(8'h98, 32'h0, "R1 ctrl w9 after reset");

        // Program windows
        wr(8'h00, 32'h000F_1D3F);   // w0 ctrl, bits 3:1 set
        wr(8'h04, 32'h1000_FFF0);   // w0 base
        wr(8'h08, 32'hA000_FFFF);   // w0 remap low
        wr(8'h0C, 32'hFFFF_FFF2);   // w0 remap high
        wr(8'h20, 32'h0000_2251);   // w2 ctrl, 64 KiB
        wr(8'h24, 32'h3000_0002);   // w2 base 0x2_3000_0000
        wr(8'h50, 32'h0000_FF60);   // w5 ctrl, disabled
        wr(8'h54, 32'h5000_0000);
        wr(8'h98, 32'h00FF_0A71);   // w9 ctrl, 16 MiB
        wr(8'h9C, 32'h1000_0000);
        wr(8'hE8, 32'h0001_4C91);   // w19 ctrl, 128 KiB
        wr(8'hEF, 32'hF000_ABC0);   // w19 base, low address bits ignored (R5)

        rd_chk(8'h00, 32'h000F_1D31, "R2 ctrl fields and zero bits");
        rd_chk(8'h04, 32'h1000_0000, "R3 base masked");
        rd_chk(8'h08, 32'hA000_0000, "R4 remap low kept bits");
        rd_chk(8'h0C, 32'h0000_0002, "R4 remap high kept bits");
        rd_chk(8'h24, 32'h3000_0002, "R3 base high nibble");
        rd_chk(8'h98, 32'h00FF_0A71, "R5 ctrl w9");
        rd_chk(8'hEC, 32'hF000_0000, "R5 base w19");
        rd_chk(8'h90, 32'h0000_0000, "R5 w8 untouched");

        // R6: reserved and beyond-range offsets
        wr(8'h80, 32'hFFFF_FFFF);
        wr(8'h84, 32'hFFFF_FFFF);
        wr(8'h8C, 32'hFFFF_FFFF);
        wr(8'hF0, 32'hFFFF_FFFF);
        wr(8'hFC, 32'hFFFF_FFFF);
        rd_chk(8'h84, 32'h0, "R6 reserved reads zero");
        rd_chk(8'hF0, 32'h0, "R6 beyond map reads zero");
        rd_chk(8'h90, 32'h0, "R6 w8 ctrl unchanged");
        rd_chk(8'hE8, 32'h0001_4C91, "R6 w19 ctrl unchanged");

        // Vector table: R7 R8 R9 R10 R11
        for (int i = 0; i < NV; i++) begin
            look(VEC[i].a, VEC[i].h, VEC[i].w, VEC[i].t, VEC[i].at, VEC[i].x,
                 $sformatf("R7/R8/R9/R10/R11 vector %0d", i));
        end

        // R12: clearing control disables
        wr(8'h98, 32'h0000_0000);
        look(36'h0_1020_0000, 1'b0, 5'd0, 4'h0, 8'h00, 36'h0, "R12 w9 disabled");
        look(36'h0_1002_3456, 1'b1, 5'd0, 4'h3, 8'h1D, 36'h2_A002_3456, "R12 w0 still hits");
        wr(8'h00, 32'h0000_0000);
        look(36'h0_1002_3456, 1'b0, 5'd0, 4'h0, 8'h00, 36'h0, "R12 w0 disabled");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule